// File: doc/BRIEF.md
# Asymmetric Subvector Move Sequencer

This block walks a vector move in which only one side is grouped into subvectors of 2, 3 or 4 elements. In gather mode it reads the first element of each source group and writes it to consecutive destination registers. In scatter mode it reads consecutive source registers and writes each one to the first register of a destination group. Because only one operand is grouped, the source and destination addresses advance by different strides. A third operation packs narrow 8-bit source elements, which are laid out contiguously across source registers, into 32-bit destination words, one subvector per word.

The sequencer reads the source register file through a combinational read port that it drives itself. It issues at most one registered write per cycle on the write port. A per-element predicate suppresses individual writes. A one-cycle done pulse marks the end of the operation. The external register file is treated as read-only during an operation: the sequencer never reads back a value it has just written.

Top module: `smv_seq`

## Requirements
- R1: Gather (`pack_i`=0, `mode_i`=0): for element i in 0..VL-1, register `rd+i` receives register `rs+i*SUBVL`. Register numbers wrap modulo 32.
- R2: Scatter (`pack_i`=0, `mode_i`=1): for element i in 0..VL-1, register `rd+i*SUBVL` receives register `rs+i`.
- R3: With SUBVL=1, both gather and scatter perform a plain copy from `rs+i` to `rd+i`.
- R4: Pack (`pack_i`=1, `mode_i` ignored): byte element b lives in register `rs+b/4`, bits `8*(b%4)+7 : 8*(b%4)`. Destination register `rd+i` receives byte element `i*SUBVL+j` in bits `8j+7 : 8j`. With SUBVL=4 this fills all four byte lanes.
- R5: In pack mode with SUBVL below 4, the destination byte lanes at positions SUBVL..3 are written as zero.
- R6: Element i is written only if bit i of `pred_i` is 1. When the bit is 0, no write takes place for that element and the element's write slot shows `rf_we_o`=0.
- R7: Let E0 be the rising edge at which `start_i` is accepted. In gather and scatter modes, the write for element k is presented in the cycle after edge E(k+1). In pack mode, it is presented in the cycle after edge E((k+1)*SUBVL). `rf_we_o` is 0 in all other cycles.
- R8: `done_o` is high for exactly one cycle, the cycle after edge E(T+1). T is VL for gather and scatter, and VL*SUBVL for pack.
- R9: VL=0 performs no writes, and `done_o` pulses in the cycle after E1.
- R10: `start_i` is ignored while an operation is in progress. The operation already running completes unchanged.
- R11: A SUBVL input outside 1..4 is treated as 1.
- R12: During reset and after it, `rf_we_o` and `done_o` are 0 until an operation is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe; accepted only when idle |
| mode_i | input | 1 | 0 = gather from subvectors, 1 = scatter to subvectors |
| pack_i | input | 1 | 1 = byte-packing operation (overrides mode_i) |
| rs_i | input | 5 | Source base register |
| rd_i | input | 5 | Destination base register |
| vl_i | input | 5 | Vector length, 0..16 |
| subvl_i | input | 3 | Subvector length, 1..4 |
| pred_i | input | 16 | Per-element write predicate |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 32 | Register file read data (same cycle) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 32 | Register file write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the stride asymmetry. A design that swapped the source and destination strides would write the right data to the wrong registers, or the wrong data to consecutive registers. Pack runs with SUBVL of 4, 3 and 2 make byte elements cross register boundaries. These runs catch a design that reverses the lane order, fails to clear the accumulator between words, or leaves stale upper bytes. Sparse predicates, VL=0, a restart strobe in mid-operation and illegal SUBVL values check the following faults: a write leaking out of a masked slot, a missing or doubled done pulse, an operation corrupted by a late start, and a fault on an out-of-range group size.

// File: rtl/smv_pkg.sv
// Shared types for the subvector move sequencer.
// Assumes SUBVL is encoded in 3 bits; only 1..4 are legal group sizes.
package smv_pkg;

    // Operation selected at start
    typedef enum logic [1:0] {
        OP_GATHER  = 2'd0,
        OP_SCATTER = 2'd1,
        OP_PACK    = 2'd2
    } smv_op_e;

    // Sequencer phase
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } smv_state_e;

    // Map an illegal group size onto 1
    function automatic logic [2:0] norm_subvl(input logic [2:0] s);
        return (s >= 3'd1 && s <= 3'd4) ? s : 3'd1;
    endfunction

endpackage

// File: rtl/smv_ctrl.sv
// Sequencer control: accepts a start, then steps an element counter and,
// in pack mode, a byte counter inside each element.
// Assumes op_i, subvl_i and vl_i are the values latched at acceptance.
module smv_ctrl
    import smv_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [VLW-1:0]  vl_start_i,
    input  smv_op_e         op_i,
    input  logic [2:0]      subvl_i,
    input  logic [VLW-1:0]  vl_i,
    output smv_state_e      state_o,
    output logic [IW-1:0]   elem_o,
    output logic [1:0]      byte_o,
    output logic            elem_last_o,
    output logic            accept_o
);

    smv_state_e     state_q;
    logic [IW-1:0]  elem_q;
    logic [1:0]     byte_q;
    logic           elem_final;

    // Acceptance only from idle
    assign accept_o = start_i && (state_q == ST_IDLE);

    // Last cycle of the current element
    assign elem_last_o = (op_i != OP_PACK) || ({1'b0, byte_q} == (subvl_i - 3'd1));

    // Last element of the vector
    assign elem_final = (VLW'(elem_q) == (vl_i - VLW'(1)));

    // Phase and counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            elem_q  <= '0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        elem_q  <= '0;
                        byte_q  <= '0;
                        state_q <= (vl_start_i == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!elem_last_o) begin
                        byte_q <= byte_q + 2'd1;
                    end else begin
                        byte_q <= '0;
                        if (elem_final) begin
                            elem_q  <= '0;
                            state_q <= ST_FIN;
                        end else begin
                            elem_q <= elem_q + IW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign elem_o  = elem_q;
    assign byte_o  = byte_q;

    // R9: a zero-length start goes straight to the finishing phase
    assert_zero_vl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && vl_start_i == '0) |=> (state_q == ST_FIN));

    // R1: the element counter never passes the latched length
    assert_elem_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (VLW'(elem_q) < vl_i));

endmodule

// File: rtl/smv_addr.sv
// Address generator: derives the read address, write address and byte lane
// from the element and byte counters. Gather strides the source, scatter
// strides the destination, and pack walks contiguous source bytes.
// Assumes the register count is a power of two, so addresses wrap.
module smv_addr
    import smv_pkg::*;
#(
    parameter int AW    = 5,
    parameter int IW    = 4,
    parameter int LANES = 4,
    parameter int LW    = $clog2(LANES)
) (
    input  smv_op_e        op_i,
    input  logic [AW-1:0]  rs_i,
    input  logic [AW-1:0]  rd_i,
    input  logic [2:0]     subvl_i,
    input  logic [IW-1:0]  elem_i,
    input  logic [1:0]     byte_i,
    output logic [AW-1:0]  raddr_o,
    output logic [AW-1:0]  waddr_o,
    output logic [LW-1:0]  lane_o
);

    localparam int GW = IW + 3;

    logic [GW-1:0] grp;
    logic [GW-1:0] bidx;

    // Group offset and flat byte index
    always_comb begin
        grp  = GW'(elem_i) * GW'(subvl_i);
        bidx = grp + GW'(byte_i);
    end

    // Stride selection per operation
    always_comb begin
        lane_o = bidx[LW-1:0];
        case (op_i)
            OP_SCATTER: begin
                raddr_o = rs_i + AW'(elem_i);
                waddr_o = rd_i + AW'(grp);
            end
            OP_PACK: begin
                raddr_o = rs_i + AW'(bidx >> LW);
                waddr_o = rd_i + AW'(elem_i);
            end
            default: begin
                raddr_o = rs_i + AW'(grp);
                waddr_o = rd_i + AW'(elem_i);
            end
        endcase
    end

endmodule

// File: rtl/smv_pack.sv
// Byte packer: selects one byte lane of the read data each cycle and
// merges it into position byte_i of a word under construction.
// Assumes byte_i restarts at 0 for every destination word.
module smv_pack #(
    parameter int XLEN  = 32,
    parameter int LANES = XLEN / 8,
    parameter int LW    = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [2:0]       subvl_i,
    input  logic [XLEN-1:0]  rdata_i,
    input  logic [LW-1:0]    lane_i,
    input  logic [1:0]       byte_i,
    output logic [XLEN-1:0]  word_o
);

    logic [7:0]       lane_bytes [LANES];
    logic [7:0]       sel_byte;
    logic [XLEN-1:0]  acc_q;

    // Split the read word into byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = rdata_i[8*g +: 8];
    end

    assign sel_byte = lane_bytes[lane_i];

    // Merge the selected byte; the first byte clears older contents
    always_comb begin
        word_o = ((byte_i == 2'd0) ? '0 : acc_q)
               | (XLEN'(sel_byte) << {byte_i, 3'b000});
    end

    // Hold the partial word between byte cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (active_i) begin
            acc_q <= word_o;
        end
    end

    // R5: byte position stays inside the group size
    assert_byte_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> ({1'b0, byte_i} < subvl_i));

endmodule

// File: rtl/smv_seq.sv
// Top of the subvector move sequencer. Latches the operation at start,
// drives a combinational read of the source register file, and registers
// one predicated write per element, followed by a one-cycle done pulse.
// Assumes the register file returns read data in the same cycle and that
// no write in flight targets a register still to be read.
module smv_seq
    import smv_pkg::*;
#(
    parameter int AW    = 5,
    parameter int XLEN  = 32,
    parameter int MAXVL = 16,
    parameter int VLW   = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL),
    parameter int LANES = XLEN / 8,
    parameter int LW    = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             pack_i,
    input  logic [AW-1:0]    rs_i,
    input  logic [AW-1:0]    rd_i,
    input  logic [VLW-1:0]   vl_i,
    input  logic [2:0]       subvl_i,
    input  logic [MAXVL-1:0] pred_i,
    output logic [AW-1:0]    rf_raddr_o,
    input  logic [XLEN-1:0]  rf_rdata_i,
    output logic             rf_we_o,
    output logic [AW-1:0]    rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             done_o
);

    smv_op_e            op_q;
    logic [AW-1:0]      rs_q;
    logic [AW-1:0]      rd_q;
    logic [VLW-1:0]     vl_q;
    logic [2:0]         subvl_q;
    logic [MAXVL-1:0]   pred_q;

    smv_state_e         state;
    logic [IW-1:0]      elem;
    logic [1:0]         byte_idx;
    logic               elem_last;
    logic               accept;
    logic [AW-1:0]      waddr_c;
    logic [LW-1:0]      lane;
    logic [XLEN-1:0]    packed_word;
    logic               wr_fire;

    logic               we_q;
    logic [AW-1:0]      waddr_q;
    logic [XLEN-1:0]    wdata_q;
    logic               done_q;

    // Capture the operation when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_GATHER;
            rs_q    <= '0;
            rd_q    <= '0;
            vl_q    <= '0;
            subvl_q <= 3'd1;
            pred_q  <= '0;
        end else if (accept) begin
            op_q    <= pack_i ? OP_PACK : (mode_i ? OP_SCATTER : OP_GATHER);
            rs_q    <= rs_i;
            rd_q    <= rd_i;
            vl_q    <= vl_i;
            subvl_q <= norm_subvl(subvl_i);
            pred_q  <= pred_i;
        end
    end

    smv_ctrl #(
        .MAXVL (MAXVL),
        .VLW   (VLW),
        .IW    (IW)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .vl_start_i  (vl_i),
        .op_i        (op_q),
        .subvl_i     (subvl_q),
        .vl_i        (vl_q),
        .state_o     (state),
        .elem_o      (elem),
        .byte_o      (byte_idx),
        .elem_last_o (elem_last),
        .accept_o    (accept)
    );

    smv_addr #(
        .AW    (AW),
        .IW    (IW),
        .LANES (LANES),
        .LW    (LW)
    ) i_addr (
        .op_i    (op_q),
        .rs_i    (rs_q),
        .rd_i    (rd_q),
        .subvl_i (subvl_q),
        .elem_i  (elem),
        .byte_i  (byte_idx),
        .raddr_o (rf_raddr_o),
        .waddr_o (waddr_c),
        .lane_o  (lane)
    );

    smv_pack #(
        .XLEN  (XLEN),
        .LANES (LANES),
        .LW    (LW)
    ) i_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i ((state == ST_RUN) && (op_q == OP_PACK)),
        .subvl_i  (subvl_q),
        .rdata_i  (rf_rdata_i),
        .lane_i   (lane),
        .byte_i   (byte_idx),
        .word_o   (packed_word)
    );

    // An element completes and its predicate allows the write
    assign wr_fire = (state == ST_RUN) && elem_last && pred_q[elem];

    // Register the write port and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            we_q   <= wr_fire;
            done_q <= (state == ST_FIN);
            if (wr_fire) begin
                waddr_q <= waddr_c;
                wdata_q <= (op_q == OP_PACK) ? packed_word : rf_rdata_i;
            end
        end
    end

    assign rf_we_o    = we_q;
    assign rf_waddr_o = waddr_q;
    assign rf_wdata_o = wdata_q;
    assign done_o     = done_q;

    // R8: completion is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: a write only follows a cycle spent stepping elements
    assert_write_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(state == ST_RUN));

    // R10: latched operation holds while busy
    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(rs_q) && $stable(rd_q) && $stable(vl_q)
                                && $stable(op_q) && $stable(pred_q)));

endmodule

// File: tb/test_smv_seq.sv
module test_smv_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 32;
    localparam int SLOTS      = 80;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        mode_i;
    logic        pack_i;
    logic [4:0]  rs_i;
    logic [4:0]  rd_i;
    logic [4:0]  vl_i;
    logic [2:0]  subvl_i;
    logic [15:0] pred_i;
    logic [4:0]  rf_raddr_o;
    logic [31:0] rf_rdata_i;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        done_o;

    logic [31:0] rf [NREG];
    logic        exp_we   [SLOTS];
    logic [4:0]  exp_addr [SLOTS];
    logic [31:0] exp_data [SLOTS];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata_i = rf[rf_raddr_o];

    smv_seq i_smv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .pack_i     (pack_i),
        .rs_i       (rs_i),
        .rd_i       (rd_i),
        .vl_i       (vl_i),
        .subvl_i    (subvl_i),
        .pred_i     (pred_i),
        .rf_raddr_o (rf_raddr_o),
        .rf_rdata_i (rf_rdata_i),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .done_o     (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural model: fills the expected write slots, returns run length
    task automatic model(input bit m, input bit pk, input int rs, input int rd,
                         input int vl, input int sv, input logic [15:0] pred,
                         output int t);
        int sve = (sv >= 1 && sv <= 4) ? sv : 1;
        for (int n = 0; n < SLOTS; n++) begin
            exp_we[n] = 1'b0; exp_addr[n] = '0; exp_data[n] = '0;
        end
        if (pk) begin
            t = vl * sve;
            for (int k = 0; k < vl; k++) begin
                logic [31:0] word = '0;
                for (int j = 0; j < sve; j++) begin
                    int b = k * sve + j;
                    logic [7:0] by = 8'(rf[(rs + b / 4) % NREG] >> (8 * (b % 4)));
                    word = word | (32'(by) << (8 * j));
                end
                if (pred[k]) begin
                    exp_we[(k + 1) * sve]   = 1'b1;
                    exp_addr[(k + 1) * sve] = 5'((rd + k) % NREG);
                    exp_data[(k + 1) * sve] = word;
                end
            end
        end else begin
            t = vl;
            for (int k = 0; k < vl; k++) begin
                int src = m ? (rs + k) : (rs + k * sve);
                int dst = m ? (rd + k * sve) : (rd + k);
                if (pred[k]) begin
                    exp_we[k + 1]   = 1'b1;
                    exp_addr[k + 1] = 5'(dst % NREG);
                    exp_data[k + 1] = rf[src % NREG];
                end
            end
        end
    endtask

    // Start one operation and compare against the model on every clock
    task automatic run_op(input string tag, input bit m, input bit pk,
                          input int rs, input int rd, input int vl, input int sv,
                          input logic [15:0] pred, input bit poke);
        int t;
        model(m, pk, rs, rd, vl, sv, pred, t);
        @(negedge clk);
        mode_i = m; pack_i = pk; rs_i = 5'(rs); rd_i = 5'(rd);
        vl_i = 5'(vl); subvl_i = 3'(sv); pred_i = pred; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 1; n <= t + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(rf_we_o === exp_we[n], "R7", $sformatf("%s write enable slot %0d", tag, n),
                  32'(rf_we_o), 32'(exp_we[n]));
            if (exp_we[n] && rf_we_o === 1'b1) begin
                check(rf_waddr_o === exp_addr[n], tag, $sformatf("write address slot %0d", n),
                      32'(rf_waddr_o), 32'(exp_addr[n]));
                check(rf_wdata_o === exp_data[n], tag, $sformatf("write data slot %0d", n),
                      rf_wdata_o, exp_data[n]);
            end
            check(done_o === (n == t + 1), "R8", $sformatf("%s done slot %0d", tag, n),
                  32'(done_o), 32'(n == t + 1));
            if (poke && n == 1) begin
                // R10: a second start while busy must change nothing
                mode_i = ~m; pack_i = ~pk; rs_i = 5'd31; rd_i = 5'd0;
                vl_i = 5'd1; subvl_i = 3'd2; pred_i = 16'hFFFF; start_i = 1'b1;
            end
            if (poke && n == 2) start_i = 1'b0;
        end
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) begin
            rf[r] = {8'(r) ^ 8'h5A, 8'(r + 16), ~8'(r), 8'(r * 3 + 1)};
        end
        rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; pack_i = 1'b0;
        rs_i = '0; rd_i = '0; vl_i = '0; subvl_i = 3'd1; pred_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rf_we_o === 1'b0, "R12", "write enable in reset", 32'(rf_we_o), 0);
        check(done_o === 1'b0, "R12", "done in reset", 32'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(rf_we_o === 1'b0, "R12", "write enable after reset", 32'(rf_we_o), 0);
        check(done_o === 1'b0, "R12", "done after reset", 32'(done_o), 0);

        run_op("R1",  1'b0, 1'b0, 2,  20, 5,  3, 16'hFFFF, 1'b0);
        run_op("R1",  1'b0, 1'b0, 28, 3,  6,  4, 16'hFFFF, 1'b0);
        run_op("R2",  1'b0 ^ 1'b1, 1'b0, 1, 8, 4, 4, 16'hFFFF, 1'b0);
        run_op("R2",  1'b1, 1'b0, 10, 25, 5, 2, 16'hFFFF, 1'b0);
        run_op("R3",  1'b0, 1'b0, 4,  12, 6,  1, 16'hFFFF, 1'b0);
        run_op("R3",  1'b1, 1'b0, 9,  17, 7,  1, 16'hFFFF, 1'b0);
        run_op("R4",  1'b0, 1'b1, 4,  24, 3,  4, 16'hFFFF, 1'b0);
        run_op("R4",  1'b1, 1'b1, 30, 0,  16, 4, 16'hFFFF, 1'b0);
        run_op("R5",  1'b0, 1'b1, 6,  14, 5,  3, 16'hFFFF, 1'b0);
        run_op("R5",  1'b0, 1'b1, 11, 2,  7,  2, 16'hFFFF, 1'b0);
        run_op("R6",  1'b0, 1'b0, 3,  16, 5,  2, 16'b10110, 1'b0);
        run_op("R6",  1'b1, 1'b0, 0,  5,  6,  3, 16'b101001, 1'b0);
        run_op("R6",  1'b0, 1'b1, 8,  21, 4,  3, 16'b0101, 1'b0);
        run_op("R9",  1'b0, 1'b0, 5,  6,  0,  2, 16'hFFFF, 1'b0);
        run_op("R9",  1'b0, 1'b1, 5,  6,  0,  4, 16'hFFFF, 1'b0);
        run_op("R10", 1'b0, 1'b0, 7,  18, 6,  2, 16'hFFFF, 1'b1);
        run_op("R10", 1'b0, 1'b1, 1,  9,  3,  4, 16'h0007, 1'b1);
        run_op("R11", 1'b0, 1'b0, 12, 22, 4,  0, 16'hFFFF, 1'b0);
        run_op("R11", 1'b1, 1'b0, 12, 22, 4,  7, 16'hFFFF, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule